// File: doc/BRIEF.md
# Masked Vector Element Executor

This block runs one element-wise vector operation at a time under a per-element mask. A caller presents two source vectors, an active length and a command, then pulses `start`. Element commands (multiply, add, copy of either source) produce one result per enabled element. Each result leaves through a write port that carries the element index, the data and a write enable. The destination register lives outside the block. Positions whose mask bit is clear keep their old value.

The mask register is internal and is always visible on `mask_o`. Mask commands take one cycle. One sets each bit from a nonzero test on source A. One sets each bit from a signed greater-or-equal compare of A against B. One inverts the whole mask, so a second operation can cover the positions the first one skipped. One enables every position.

For element commands, `dense` picks the execution scheme. In gated mode every position below the length is stepped through, and the mask only gates the write enable. In density-time mode a priority picker visits only the enabled positions, so the run time follows the number of set bits.

Top module: `mask_vec_exec`

## Requirements
- R1: After reset `busy`, `done` and `wr_en` are low and `mask_o` is all ones.
- R2: Command 3'b100 (accepted when not busy) sets mask bit i to 1 when element i of `src_a` is nonzero and i is below the effective length, else 0. The new mask shows on `mask_o` in the cycle after the start edge, `done` pulses in that same cycle, and `busy` stays low.
- R3: Command 3'b101 sets mask bit i to 1 when element i of `src_a` is greater than or equal to element i of `src_b` as two's-complement values and i is below the effective length, else 0. Its timing is the same as R2.
- R4: Command 3'b110 inverts all N mask bits. Its timing is the same as R2.
- R5: Command 3'b111 sets all N mask bits. Its timing is the same as R2.
- R6: The element commands are 3'b000 for the product modulo 2^EW, 3'b001 for the sum modulo 2^EW, 3'b010 to copy A and 3'b011 to copy B. Element i of a vector occupies bits [i*EW +: EW]. After the run, each destination element holds the result where the mask bit is set and i is below the length, and its old value everywhere else.
- R7: With `dense`=0, positions 0 to L-1 are stepped through one per cycle in ascending order, and `wr_en` equals the mask bit for each position. `done` rises L+1 clock edges after the start edge, whatever the mask holds.
- R8: With `dense`=1, only positions with a set mask bit below L are written, in ascending index order and on back-to-back cycles. `done` rises P+1 edges after the start edge, where P is the number of such positions.
- R9: `done` is a one-cycle pulse that comes one cycle after the last write. When no position is enabled, the run produces no write at all.
- R10: A `start` that arrives while `busy` is high is ignored. It changes neither the mask nor the running operation.
- R11: A `vlen` value greater than N is treated as N, for both mask commands and element commands.
- R12: `wr_en` is high only while an operation is running, and only for an index whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| cmd | input | 3 | Command code |
| dense | input | 1 | 1 selects density-time scheme, 0 selects gated writeback |
| vlen | input | $clog2(N_ELEM+1) | Active vector length |
| src_a | input | N_ELEM*EW | Source vector A |
| src_b | input | N_ELEM*EW | Source vector B |
| busy | output | 1 | Element operation in progress |
| done | output | 1 | Completion pulse |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | $clog2(N_ELEM) | Destination element index |
| wr_data | output | EW | Destination element data |
| mask_o | output | N_ELEM | Current mask register |

## Verification
Several properties hold on every cycle and are checked continuously:
- a write always targets an in-range index whose mask bit is set, and happens only during a run;
- writes that follow one another go to strictly increasing indices;
- the mask cannot move while a run is active;
- `done` never coincides with `busy`.

Other behaviours can only be shown by the bench's scenarios, which compare against a merged reference of old and new destination values:
- the arithmetic results;
- the compare and nonzero tests, with signed operands;
- the exact run lengths of the two schemes;
- clamping of an oversized length;
- the empty-mask case, where `done` arrives with no writes.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [2:0] {
    CMD_MUL = 3'b000,
    CMD_ADD = 3'b001,
    CMD_CPA = 3'b010,
    CMD_CPB = 3'b011,
    CMD_MNZ = 3'b100,
    CMD_MGE = 3'b101,
    CMD_MINV = 3'b110,
    CMD_MALL = 3'b111
  } mvx_cmd_e;

  function automatic logic is_mask_cmd(input logic [2:0] c);
    return c[2];
  endfunction
endpackage

// File: rtl/mvx_pick.sv
module mvx_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    onehot = found ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/mvx_lane_op.sv
module mvx_lane_op #(
  parameter int EW = 8
) (
  input  logic [1:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y
);
  always_comb begin
    unique case (op)
      2'b00:   y = a * b;
      2'b01:   y = a + b;
      2'b10:   y = a;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mask_vec_exec.sv
module mask_vec_exec
  import mvx_pkg::*;
#(
  parameter int N_ELEM = 8,
  parameter int EW     = 8,
  localparam int IW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int LW    = $clog2(N_ELEM + 1),
  localparam int VW    = N_ELEM * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cmd,
  input  logic          dense,
  input  logic [LW-1:0] vlen,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [EW-1:0] wr_data,
  output logic [N_ELEM-1:0] mask_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // control state
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              dense_q;
  logic [N_ELEM-1:0] mask_q, mask_d;
  logic [N_ELEM-1:0] pend_q, pend_d;
  logic [LW-1:0]     cnt_q, cnt_d;
  logic [LW-1:0]     len_q;
  logic [1:0]        op_q;
  logic              wr_en_q, wr_en_d;
  // datapath state
  logic [VW-1:0]     a_q, b_q;
  logic [IW-1:0]     wr_idx_q;
  logic [EW-1:0]     wr_data_q;

  // length clamp and per-lane length/compare masks
  logic [LW-1:0]     veff;
  logic [N_ELEM-1:0] lenm, nzm, gem;
  assign veff = (vlen > LW'(N_ELEM)) ? LW'(N_ELEM) : vlen;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_lane
    assign lenm[i] = (LW'(i) < veff);
    assign nzm[i]  = lenm[i] && (src_a[i*EW +: EW] != '0);
    assign gem[i]  = lenm[i] &&
                     ($signed(src_a[i*EW +: EW]) >= $signed(src_b[i*EW +: EW]));
  end

  // density-time picker over the pending set
  logic              pk_found;
  logic [IW-1:0]     pk_idx;
  logic [N_ELEM-1:0] pk_hot;
  mvx_pick #(.N(N_ELEM)) u_pick (
    .req(pend_q), .found(pk_found), .idx(pk_idx), .onehot(pk_hot)
  );

  // issue stage
  logic          iss_vld, iss_en, finish, accept;
  logic [IW-1:0] iss_idx;
  logic [EW-1:0] lane_y;
  always_comb begin
    if (dense_q) begin
      iss_vld = busy_q && pk_found;
      iss_idx = pk_idx;
      iss_en  = 1'b1;
    end else begin
      iss_vld = busy_q && (cnt_q < len_q);
      iss_idx = IW'(cnt_q);
      iss_en  = mask_q[iss_idx];
    end
  end

  mvx_lane_op #(.EW(EW)) u_op (
    .op(op_q), .a(a_q[iss_idx*EW +: EW]), .b(b_q[iss_idx*EW +: EW]), .y(lane_y)
  );

  assign accept = start && !busy_q;
  assign finish = busy_q && !iss_vld;

  // next state
  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    mask_d  = mask_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    wr_en_d = iss_vld && iss_en;
    if (accept) begin
      if (is_mask_cmd(cmd)) begin
        done_d = 1'b1;
        unique case (mvx_cmd_e'(cmd))
          CMD_MNZ:  mask_d = nzm;
          CMD_MGE:  mask_d = gem;
          CMD_MINV: mask_d = ~mask_q;
          default:  mask_d = '1;
        endcase
      end else begin
        busy_d = 1'b1;
        pend_d = mask_q & lenm;
        cnt_d  = '0;
      end
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (iss_vld) begin
      if (dense_q) pend_d = pend_q & ~pk_hot;
      else         cnt_d  = cnt_q + LW'(1);
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mask_q  <= '1;
      pend_q  <= '0;
      cnt_q   <= '0;
      wr_en_q <= 1'b0;
      dense_q <= 1'b0;
      len_q   <= '0;
      op_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      wr_en_q <= wr_en_d;
      if (accept && !is_mask_cmd(cmd)) begin
        dense_q <= dense;
        len_q   <= veff;
        op_q    <= cmd[1:0];
      end
    end
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept && !is_mask_cmd(cmd)) begin
      a_q <= src_a;
      b_q <= src_b;
    end
    if (iss_vld) begin
      wr_idx_q  <= iss_idx;
      wr_data_q <= lane_y;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wr_en   = wr_en_q;
  assign wr_idx  = wr_idx_q;
  assign wr_data = wr_data_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/mask_vec_exec_chk.sv
module mask_vec_exec_chk #(
  parameter int N_ELEM = 8,
  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic [N_ELEM-1:0] mask_o
);
  assert_wr_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_wr_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < N_ELEM) && mask_o[wr_idx]);

  assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx)));

  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_o));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind mask_vec_exec mask_vec_exec_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_idx(wr_idx), .mask_o(mask_o)
);

// File: tb/mask_vec_exec_tb.sv
module mask_vec_exec_tb;
  localparam int N  = 8;
  localparam int EW = 8;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    cmd;
  logic          dense;
  logic [3:0]    vlen;
  logic [63:0]   src_a, src_b;
  logic          busy, done, wr_en;
  logic [2:0]    wr_idx;
  logic [7:0]    wr_data;
  logic [7:0]    mask_o;

  always #4 clk = ~clk;

  mask_vec_exec #(.N_ELEM(N), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .dense(dense),
    .vlen(vlen), .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .mask_o(mask_o)
  );

  // {cmd[3], dense[1], vlen[4], a[64], b[64]}
  localparam logic [135:0] TBL [NV] = '{
    {3'd7, 1'b0, 4'd8, 64'h0, 64'h0},
    {3'd0, 1'b0, 4'd8, 64'h0807_0605_0403_0201, 64'h1111_2222_0303_0909},
    {3'd4, 1'b0, 4'd8, 64'h0900_3300_0000_7A01, 64'h0},
    {3'd1, 1'b1, 4'd8, 64'h1020_3040_5060_7080, 64'h0101_0101_0101_0101},
    {3'd5, 1'b0, 4'd8, 64'hF906_00FB_0403_0201, 64'hF805_FDFC_0A02_0202},
    {3'd2, 1'b1, 4'd8, 64'hF906_00FB_0403_0201, 64'hF805_FDFC_0A02_0202},
    {3'd6, 1'b0, 4'd8, 64'h0, 64'h0},
    {3'd3, 1'b0, 4'd8, 64'hF906_00FB_0403_0201, 64'hF805_FDFC_0A02_0202},
    {3'd4, 1'b0, 4'd5, 64'h1111_1111_0011_0011, 64'h0},
    {3'd0, 1'b1, 4'd3, 64'hFFFF_FFFF_FF10_0F03, 64'h0202_0202_0210_1005},
    {3'd4, 1'b0, 4'd8, 64'h0, 64'h0},
    {3'd1, 1'b1, 4'd8, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111},
    {3'd1, 1'b0, 4'd6, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111},
    {3'd7, 1'b0, 4'd0, 64'h0, 64'h0},
    {3'd0, 1'b0, 4'hF, 64'h0303_0303_0303_0303, 64'h0505_0505_0505_0505},
    {3'd5, 1'b0, 4'hF, 64'h0102_0304_0506_0708, 64'h0808_0808_0101_0101}
  };

  int unsigned nchk = 0, nfail = 0;
  logic [7:0]  dact [N];
  logic [7:0]  dexp [N];
  logic [7:0]  mexp;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic [7:0] d [N]);
    logic [63:0] r;
    for (int i = 0; i < N; i++) r[i*8 +: 8] = d[i];
    return r;
  endfunction

  function automatic logic [7:0] lane_res(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      2'd0: return 8'(a * b);
      2'd1: return 8'(a + b);
      2'd2: return a;
      default: return b;
    endcase
  endfunction

  // run one command; returns edges from start edge to done, and write count
  task automatic run_cmd(input logic [2:0] c, input logic d, input logic [3:0] v,
                         input logic [63:0] a, input logic [63:0] b,
                         output int edges, output int writes, input bit poke_busy);
    @(negedge clk);
    start = 1'b1; cmd = c; dense = d; vlen = v; src_a = a; src_b = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0; writes = 0;
    while (edges < 300) begin
      if (wr_en) begin dact[wr_idx] = wr_data; writes++; end
      if (done) break;
      if (poke_busy && edges == 2) begin start = 1'b1; cmd = 3'd6; end
      else start = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    start = 1'b0;
    if (edges >= 300) begin nchk++; nfail++; $display("FAIL R9 watchdog act=timeout exp=done"); end
  endtask

  // reference model for one command
  task automatic model(input logic [2:0] c, input logic d, input logic [3:0] v,
                       input logic [63:0] a, input logic [63:0] b,
                       output int exp_edges, output int exp_writes);
    int veff;
    int pc;
    veff = (v > N) ? N : int'(v);
    pc = 0;
    if (c[2]) begin
      for (int i = 0; i < N; i++) begin
        case (c)
          3'd4: mexp[i] = (i < veff) && (a[i*8 +: 8] != 0);
          3'd5: mexp[i] = (i < veff) && ($signed(a[i*8 +: 8]) >= $signed(b[i*8 +: 8]));
          3'd6: mexp[i] = ~mexp[i];
          default: mexp[i] = 1'b1;
        endcase
      end
      exp_edges = 0; exp_writes = 0;
    end else begin
      for (int i = 0; i < veff; i++)
        if (mexp[i]) begin
          dexp[i] = lane_res(c[1:0], a[i*8 +: 8], b[i*8 +: 8]);
          pc++;
        end
      exp_writes = pc;
      exp_edges = d ? pc + 1 : veff + 1;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL R9 global watchdog act=hung exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int ed, wr, xe, xw;
    string mtag;
    string ttag;
    rst_n = 1'b0; start = 1'b0; cmd = '0; dense = 1'b0; vlen = '0;
    src_a = '0; src_b = '0;
    for (int i = 0; i < N; i++) begin dact[i] = 8'hE0 + 8'(i); dexp[i] = 8'hE0 + 8'(i); end
    mexp = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 wr_en", 64'(wr_en), 64'd0);
    chk("R1 mask", 64'(mask_o), 64'hFF);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [2:0] c; logic d; logic [3:0] v; logic [63:0] a, b;
      {c, d, v, a, b} = TBL[k];
      model(c, d, v, a, b, xe, xw);
      run_cmd(c, d, v, a, b, ed, wr, 1'b0);
      case (c)
        3'd4: mtag = "R2 mask";
        3'd5: mtag = "R3 mask";
        3'd6: mtag = "R4 mask";
        3'd7: mtag = "R5 mask";
        default: mtag = "R6 mask-kept";
      endcase
      if (v > N) mtag = {mtag, " R11"};
      ttag = c[2] ? "R2 latency" : (d ? "R8 latency" : "R7 latency");
      if (v > N) ttag = "R11 latency";
      chk(mtag, 64'(mask_o), 64'(mexp));
      chk(ttag, 64'(ed), 64'(xe));
      chk("R9 write count", 64'(wr), 64'(xw));
      chk("R6 destination", pack(dact), pack(dexp));
    end

    // R10: start during a run must be ignored
    model(3'd7, 1'b0, 4'd8, 64'h0, 64'h0, xe, xw);
    run_cmd(3'd7, 1'b0, 4'd8, 64'h0, 64'h0, ed, wr, 1'b0);
    model(3'd1, 1'b0, 4'd8, 64'h2020_2020_2020_2020, 64'h0102_0304_0506_0708, xe, xw);
    run_cmd(3'd1, 1'b0, 4'd8, 64'h2020_2020_2020_2020, 64'h0102_0304_0506_0708, ed, wr, 1'b1);
    repeat (2) @(negedge clk);
    chk("R10 mask unchanged", 64'(mask_o), 64'hFF);
    chk("R10 run length", 64'(ed), 64'(xe));
    chk("R10 destination", pack(dact), pack(dexp));
    chk("R12 idle wr_en", 64'(wr_en), 64'd0);
    chk("R9 done low after pulse", 64'(done), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule